// File: doc/BRIEF.md
# Dual-Event Performance Counter Unit

This unit counts processor events in two 32-bit counters, a lower one and an upper one. Each counter picks the event it follows through its own 6-bit code field in a control register. One pair of privilege enables sits in the same register: one bit for user mode, one for supervisor mode. Both counters share this pair. A counter therefore cannot be halted alone. A counter that software does not need is instead pointed at a parking code, which follows a dummy instruction that ordinary code almost never runs.

The core sends one strobe per event type (clock cycle, retired instruction, cache access, cache miss, dummy instruction) together with its current privilege mode. Software reaches three registers through a flat read/write port: control, the packed counter pair, and a sticky overflow status. Software preloads a counter with the two's complement of N to take an interrupt after N events. The interrupt is a level that stays high while any status bit is set.

Top module: `perf_counter_unit`

## Requirements
- R1: After a synchronous reset both counters read 0, the status register reads 0, irq is low, both enables are clear, and the event fields hold their parking codes: the upper field holds 0x1C and the lower field holds 0x14, so control reads 0xE140.
- R2: The register port decodes reg_addr as 0 = control, 1 = counter pair, 2 = overflow status, 3 = unused. Address 3 reads 0 and ignores writes. Control places the user enable at bit 0, the supervisor enable at bit 1, the lower event code in bits 9:4 and the upper event code in bits 16:11. All other control bits read as 0. Reads are combinational, and a control write takes effect from the next clock.
- R3: A write to address 1 loads the upper counter from bits 63:32 and the lower counter from bits 31:0 in the same clock. On both counters the write takes priority over any event in that cycle.
- R4: A counter advances by exactly one in a clock only when the strobe for its selected event is high and the enable for the current mode is set. priv_mode 0 is user mode (bit 0) and priv_mode 1 is supervisor mode (bit 1). In every other case the counter holds.
- R5: On the upper counter, code 0x00 follows strobe bit 0 (cycles), code 0x01 follows bit 1 (retired instructions), code 0x09 follows bit 3 (cache misses) and code 0x1C follows bit 4 (dummy instruction).
- R6: On the lower counter, code 0x00 follows bit 0, code 0x01 follows bit 1, code 0x09 follows bit 2 (cache accesses) and code 0x14 follows bit 4.
- R7: Any other code never counts, and this includes each counter's parking code when it is placed in the other counter's field.
- R8: A counter that increments from 0xFFFFFFFF to 0 sets its sticky status bit (bit 1 for upper, bit 0 for lower) at the same clock edge. irq is high whenever any status bit is set. A preload of 0xFFFFFFFF does not set a status bit.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it alone. If a wrap happens in the same clock as the clearing write, the bit ends up set.
- R10: A counter preloaded with the two's complement of N wraps and raises irq on the Nth counted event, and not before.
- R11: A parked counter still counts dummy-instruction strobes while an enable for the current mode is set, and it can wrap and interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for the selected register |
| priv_mode | input | 1 | Current privilege mode: 0 user, 1 supervisor |
| event_strobe | input | 5 | Event strobes: cycle, retired, cache access, cache miss, dummy |
| irq | output | 1 | Overflow interrupt level |

## Verification
The assertions assume only that reset is held at the first clock edge and that reg_addr, reg_wr and the strobes are known values at every edge. They make no assumption about which strobes occur together, because every strobe combination is legal.

The random stimulus drives all 32 strobe patterns, both modes and all four addresses. It writes control words with junk in the reserved bits, and it biases counter preloads toward values just below the wrap point so that overflow, set-and-clear collisions and parked-counter interrupts occur many times in one run.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

    localparam int CNT_W       = 32;
    localparam int NUM_SLICES  = 2;
    localparam int DATA_W      = CNT_W * NUM_SLICES;
    localparam int EVT_W       = 6;
    localparam int ADDR_W      = 2;
    localparam int NUM_STROBES = 5;

    // slice indices inside the packed counter word
    localparam int SLICE_LO = 0;
    localparam int SLICE_UP = 1;

    // control word layout
    localparam int USR_EN_BIT = 0;
    localparam int SUP_EN_BIT = 1;
    localparam int LO_EVT_LSB = 4;
    localparam int UP_EVT_LSB = 11;

    // strobe positions
    localparam int STB_CYCLE   = 0;
    localparam int STB_RETIRE  = 1;
    localparam int STB_DC_ACC  = 2;
    localparam int STB_DC_MISS = 3;
    localparam int STB_DUMMY   = 4;

    // event codes
    localparam logic [EVT_W-1:0] EVT_CYCLES  = 6'h00;
    localparam logic [EVT_W-1:0] EVT_RETIRED = 6'h01;
    localparam logic [EVT_W-1:0] EVT_CACHE   = 6'h09;
    localparam logic [EVT_W-1:0] PARK_UP     = 6'h1C;
    localparam logic [EVT_W-1:0] PARK_LO     = 6'h14;

    typedef logic [CNT_W-1:0] count_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_STATUS = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [EVT_W-1:0] up_evt;
        logic [EVT_W-1:0] lo_evt;
        logic             sup_en;
        logic             usr_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_reset_value();
        ctrl_t c;
        c.up_evt = PARK_UP;
        c.lo_evt = PARK_LO;
        c.sup_en = 1'b0;
        c.usr_en = 1'b0;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[UP_EVT_LSB +: EVT_W] = c.up_evt;
        w[LO_EVT_LSB +: EVT_W] = c.lo_evt;
        w[SUP_EN_BIT]          = c.sup_en;
        w[USR_EN_BIT]          = c.usr_en;
        return w;
    endfunction

    // Maps an event code to the strobe it follows on one slice.
    function automatic logic [NUM_STROBES-1:0] event_mask(logic [EVT_W-1:0] code,
                                                          logic upper);
        logic [NUM_STROBES-1:0] m;
        m = '0;
        case (code)
            EVT_CYCLES:  m[STB_CYCLE]  = 1'b1;
            EVT_RETIRED: m[STB_RETIRE] = 1'b1;
            EVT_CACHE:   m[upper ? STB_DC_MISS : STB_DC_ACC] = 1'b1;
            default: begin
                if ((upper && code == PARK_UP) || (!upper && code == PARK_LO))
                    m[STB_DUMMY] = 1'b1;
            end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pmu_event_select.sv
module pmu_event_select
    import perfmon_pkg::*;
#(
    parameter bit IS_UPPER = 1'b0
) (
    input  logic [EVT_W-1:0]       code,
    input  logic [NUM_STROBES-1:0] strobes,
    output logic                   hit
);

    logic [NUM_STROBES-1:0] sel_mask;

    generate
        if (IS_UPPER) begin : g_upper
            assign sel_mask = event_mask(code, 1'b1);
        end else begin : g_lower
            assign sel_mask = event_mask(code, 1'b0);
        end
    endgenerate

    assign hit = |(sel_mask & strobes);

    // R7
    unmapped_code_chk: assert final ($countones(sel_mask) <= 1);

endmodule

// File: rtl/pmu_count_slice.sv
module pmu_count_slice
    import perfmon_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  count_t load_val,
    input  logic   inc,
    output count_t cnt,
    output logic   wrap
);

    assign wrap = inc && !load && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    // R3
    preload_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

    // R4
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));

endmodule

// File: rtl/pmu_ctrl_regs.sv
module pmu_ctrl_regs
    import perfmon_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctrl_wr,
    input  ctrl_t                 ctrl_wdata,
    input  logic                  stat_wr,
    input  logic [NUM_SLICES-1:0] stat_clr,
    input  logic [NUM_SLICES-1:0] wrap,
    output ctrl_t                 ctrl,
    output logic [NUM_SLICES-1:0] status
);

    logic [NUM_SLICES-1:0] clr_mask;

    assign clr_mask = stat_wr ? stat_clr : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= ctrl_reset_value();
            status <= '0;
        end else begin
            if (ctrl_wr)
                ctrl <= ctrl_wdata;
            status <= (status & ~clr_mask) | wrap;
        end
    end

    // R1
    reset_park_chk: assert property (@(posedge clk)
        rst |=> (ctrl.up_evt == PARK_UP && ctrl.lo_evt == PARK_LO &&
                 !ctrl.usr_en && !ctrl.sup_en && status == '0));

    // R8
    wrap_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap != '0) |=> ((status & $past(wrap)) == $past(wrap)));

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!stat_wr && wrap == '0) |=> $stable(status));

endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
    import perfmon_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic                   reg_wr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic                   priv_mode,
    input  logic [NUM_STROBES-1:0] event_strobe,
    output logic                   irq
);

    reg_sel_e                         sel;
    logic                             wr_ctrl;
    logic                             wr_count;
    logic                             wr_status;
    ctrl_t                            ctrl;
    ctrl_t                            ctrl_wdata;
    logic [NUM_SLICES-1:0]            status;
    logic [NUM_SLICES-1:0]            wrap;
    logic [NUM_SLICES-1:0]            hit;
    logic [NUM_SLICES-1:0]            inc;
    logic [NUM_SLICES-1:0][CNT_W-1:0] cnt_q;
    logic                             mode_en;

    assign sel       = reg_sel_e'(reg_addr);
    assign wr_ctrl   = reg_wr && (sel == REG_CTRL);
    assign wr_count  = reg_wr && (sel == REG_COUNT);
    assign wr_status = reg_wr && (sel == REG_STATUS);

    assign ctrl_wdata.up_evt = reg_wdata[UP_EVT_LSB +: EVT_W];
    assign ctrl_wdata.lo_evt = reg_wdata[LO_EVT_LSB +: EVT_W];
    assign ctrl_wdata.sup_en = reg_wdata[SUP_EN_BIT];
    assign ctrl_wdata.usr_en = reg_wdata[USR_EN_BIT];

    // shared privilege gate for both slices
    assign mode_en = priv_mode ? ctrl.sup_en : ctrl.usr_en;

    pmu_ctrl_regs i_ctrl_regs (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (wr_ctrl),
        .ctrl_wdata (ctrl_wdata),
        .stat_wr    (wr_status),
        .stat_clr   (reg_wdata[NUM_SLICES-1:0]),
        .wrap       (wrap),
        .ctrl       (ctrl),
        .status     (status)
    );

    generate
        for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
            localparam bit UPPER = (g == SLICE_UP);
            logic [EVT_W-1:0] code;

            assign code = UPPER ? ctrl.up_evt : ctrl.lo_evt;

            pmu_event_select #(.IS_UPPER(UPPER)) i_sel (
                .code    (code),
                .strobes (event_strobe),
                .hit     (hit[g])
            );

            assign inc[g] = mode_en && hit[g];

            pmu_count_slice i_cnt (
                .clk      (clk),
                .rst      (rst),
                .load     (wr_count),
                .load_val (reg_wdata[g*CNT_W +: CNT_W]),
                .inc      (inc[g]),
                .cnt      (cnt_q[g]),
                .wrap     (wrap[g])
            );
        end
    endgenerate

    always_comb begin
        case (sel)
            REG_CTRL:   reg_rdata = ctrl_to_word(ctrl);
            REG_COUNT:  reg_rdata = cnt_q;
            REG_STATUS: reg_rdata = {{(DATA_W-NUM_SLICES){1'b0}}, status};
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = |status;

    // R4
    all_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.usr_en && !ctrl.sup_en && !wr_count) |=> $stable(cnt_q));

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(wrap) != '0));

endmodule

// File: tb/test_perf_counter_unit.sv
module test_perf_counter_unit;

    localparam int CLK_PERIOD = 10;
    localparam int RAND_STEPS = 4000;

    logic        clk;
    logic        rst;
    logic [1:0]  reg_addr;
    logic        reg_wr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        priv_mode;
    logic [4:0]  event_strobe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    logic [63:0] m_ctl;
    logic [31:0] m_cu;
    logic [31:0] m_cl;
    logic [1:0]  m_st;

    perf_counter_unit i_perf_counter_unit (
        .clk          (clk),
        .rst          (rst),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .priv_mode    (priv_mode),
        .event_strobe (event_strobe),
        .irq          (irq)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    function automatic logic hit_fn(logic [5:0] code, bit upper, logic [4:0] s);
        case (code)
            6'h00: return s[0];
            6'h01: return s[1];
            6'h09: return upper ? s[3] : s[2];
            6'h1C: return upper ? s[4] : 1'b0;
            6'h14: return upper ? 1'b0 : s[4];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [63:0] model_read(logic [1:0] a);
        case (a)
            2'd0: return m_ctl;
            2'd1: return {m_cu, m_cl};
            2'd2: return {62'd0, m_st};
            default: return 64'd0;
        endcase
    endfunction

    task automatic model_update(logic [1:0] a, logic w, logic [63:0] d,
                                logic mode, logic [4:0] s);
        logic en;
        logic hu;
        logic hl;
        logic wu;
        logic wl;
        en = mode ? m_ctl[1] : m_ctl[0];
        hu = en && hit_fn(m_ctl[16:11], 1'b1, s);
        hl = en && hit_fn(m_ctl[9:4], 1'b0, s);
        wu = hu && (m_cu == 32'hFFFFFFFF) && !(w && a == 2'd1);
        wl = hl && (m_cl == 32'hFFFFFFFF) && !(w && a == 2'd1);
        if (w && a == 2'd1) begin
            m_cu = d[63:32];
            m_cl = d[31:0];
        end else begin
            m_cu = m_cu + {31'd0, hu};
            m_cl = m_cl + {31'd0, hl};
        end
        if (w && a == 2'd2)
            m_st = m_st & ~d[1:0];
        m_st = m_st | {wu, wl};
        if (w && a == 2'd0)
            m_ctl = d & 64'h1FBF3;
    endtask

    task automatic step(logic [1:0] a, logic w, logic [63:0] d,
                        logic mode, logic [4:0] s);
        @(negedge clk);
        reg_addr     = a;
        reg_wr       = w;
        reg_wdata    = d;
        priv_mode    = mode;
        event_strobe = s;
        @(posedge clk);
        model_update(a, w, d, mode, s);
    endtask

    task automatic expect_reg(string tag, logic [1:0] a, logic [63:0] exp);
        @(negedge clk);
        reg_addr     = a;
        reg_wr       = 1'b0;
        reg_wdata    = '0;
        event_strobe = '0;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s addr %0d: actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic expect_irq(string tag, logic exp);
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s irq: actual %b expected %b", tag, irq, exp);
        end
    endtask

    function automatic logic [5:0] pick_code();
        case ($urandom % 6)
            0: return 6'h00;
            1: return 6'h01;
            2: return 6'h09;
            3: return 6'h1C;
            4: return 6'h14;
            default: return 6'($urandom);
        endcase
    endfunction

    function automatic logic [31:0] pick_count();
        if ($urandom % 3 != 0)
            return 32'hFFFFFFF0 | 32'($urandom % 16);
        return $urandom;
    endfunction

    task automatic rand_step();
        logic [1:0]  a;
        logic        w;
        logic [63:0] d;
        logic        mode;
        logic [4:0]  s;
        logic [63:0] exp;
        a    = 2'($urandom);
        w    = ($urandom % 5 == 0);
        mode = 1'($urandom);
        s    = 5'($urandom);
        d    = {$urandom, $urandom};
        if (a == 2'd0) begin
            d[16:11] = pick_code();
            d[9:4]   = pick_code();
        end else if (a == 2'd1) begin
            d = {pick_count(), pick_count()};
        end
        @(negedge clk);
        reg_addr     = a;
        reg_wr       = w;
        reg_wdata    = d;
        priv_mode    = mode;
        event_strobe = s;
        #1;
        exp = model_read(a);
        checks++;
        if (reg_rdata !== exp) begin
            fails++;
            case (a)
                2'd0: $display("FAIL R2 control: actual %h expected %h", reg_rdata, exp);
                2'd1: $display("FAIL R4 counters: actual %h expected %h", reg_rdata, exp);
                2'd2: $display("FAIL R8 status: actual %h expected %h", reg_rdata, exp);
                default: $display("FAIL R2 unused address: actual %h expected %h", reg_rdata, exp);
            endcase
        end
        expect_irq("R8", |m_st);
        @(posedge clk);
        model_update(a, w, d, mode, s);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
        priv_mode = 1'b0; event_strobe = '0;
        m_ctl = 64'hE140; m_cu = '0; m_cl = '0; m_st = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg("R1", 2'd0, 64'hE140);
        expect_reg("R1", 2'd1, 64'd0);
        expect_reg("R1", 2'd2, 64'd0);
        expect_irq("R1", 1'b0);

        // R2 / R4: user enable, upper retired, lower cycles
        step(2'd0, 1'b1, 64'h801, 1'b0, 5'b00000);
        expect_reg("R2", 2'd0, 64'h801);
        repeat (3) step(2'd3, 1'b0, 64'd0, 1'b0, 5'b00011);
        repeat (2) step(2'd3, 1'b0, 64'd0, 1'b1, 5'b00011);
        repeat (2) step(2'd3, 1'b0, 64'd0, 1'b0, 5'b00001);
        expect_reg("R4", 2'd1, 64'h00000003_00000005);

        // R3: write beats events
        step(2'd1, 1'b1, 64'h00000010_00000020, 1'b0, 5'b00011);
        expect_reg("R3", 2'd1, 64'h00000010_00000020);

        // R5 / R6: code 0x09 on each side
        step(2'd0, 1'b1, 64'h4893, 1'b0, 5'b00000);
        step(2'd1, 1'b1, 64'd0, 1'b0, 5'b00000);
        repeat (2) step(2'd3, 1'b0, 64'd0, 1'b1, 5'b01000);
        expect_reg("R5", 2'd1, 64'h00000002_00000000);
        repeat (3) step(2'd3, 1'b0, 64'd0, 1'b0, 5'b00100);
        expect_reg("R6", 2'd1, 64'h00000002_00000003);

        // R7: swapped parking codes count nothing
        step(2'd0, 1'b1, 64'hA1C3, 1'b0, 5'b00000);
        repeat (4) step(2'd3, 1'b0, 64'd0, 1'b0, 5'b11111);
        expect_reg("R7", 2'd1, 64'h00000002_00000003);

        // R11: parked counters overflow on dummy strobes
        step(2'd0, 1'b1, 64'hE141, 1'b0, 5'b00000);
        step(2'd1, 1'b1, 64'hFFFFFFFF_00000000, 1'b0, 5'b00000);
        expect_reg("R8", 2'd2, 64'd0);
        step(2'd3, 1'b0, 64'd0, 1'b0, 5'b10000);
        expect_reg("R11", 2'd1, 64'h00000000_00000001);
        expect_reg("R11", 2'd2, 64'd2);
        expect_irq("R8", 1'b1);

        // R9: write-one-to-clear
        step(2'd2, 1'b1, 64'd1, 1'b0, 5'b00000);
        expect_reg("R9", 2'd2, 64'd2);
        step(2'd2, 1'b1, 64'd0, 1'b0, 5'b00000);
        expect_reg("R9", 2'd2, 64'd2);
        step(2'd2, 1'b1, 64'd2, 1'b0, 5'b00000);
        expect_reg("R9", 2'd2, 64'd0);
        expect_irq("R9", 1'b0);

        // R10: preload -5 on the lower counter
        step(2'd0, 1'b1, 64'h801, 1'b0, 5'b00000);
        step(2'd1, 1'b1, 64'h00000000_FFFFFFFB, 1'b0, 5'b00000);
        repeat (4) step(2'd3, 1'b0, 64'd0, 1'b0, 5'b00001);
        expect_reg("R10", 2'd1, 64'h00000000_FFFFFFFF);
        expect_reg("R10", 2'd2, 64'd0);
        step(2'd3, 1'b0, 64'd0, 1'b0, 5'b00001);
        expect_reg("R10", 2'd1, 64'd0);
        expect_reg("R10", 2'd2, 64'd1);
        expect_irq("R10", 1'b1);

        // R9: set wins over a clear in the same clock
        step(2'd2, 1'b1, 64'd1, 1'b0, 5'b00000);
        step(2'd1, 1'b1, 64'h00000000_FFFFFFFF, 1'b0, 5'b00000);
        step(2'd2, 1'b1, 64'd1, 1'b0, 5'b00001);
        expect_reg("R9", 2'd2, 64'd1);
        expect_reg("R2", 2'd3, 64'd0);

        for (int i = 0; i < RAND_STEPS; i++)
            rand_step();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule